// File: doc/BRIEF.md
# Linked-List Threshold Maximum Scanner

This block walks a singly linked list stored in a byte-wide synchronous ROM. It reports the largest node value that is no greater than an 8-bit bound sampled at start. Each node takes two neighbouring bytes. The lower address holds the payload and the next address holds the link to the following node. The walk always begins at address 0. A link equal to all ones (255) ends the list.

One ROM read port carries both payloads and links. The controller alternates between a value phase and a link phase on every clock. During the link phase the incoming link word is steered straight back onto the ROM address. Each node therefore costs two cycles. A step cap stops a list that loops back on itself.

The user pulses `start` with the bound on `limitX`, waits for the one-cycle `done` pulse, and then reads `result` and `found`. Both stay frozen until the next accepted start.

Top module: `llscan`

## Requirements
- R1: After reset, `done`, `found` and `result` are 0 and `romAddr` is 0.
- R2: Node i lives at ROM address a_i (payload) and a_i+1 (link), with a_0 = 0. In the cycles after the start edge, the ROM is addressed with 0, 1, a_1, a_1+1, a_2, a_2+1 and so on. Each a_(i+1) is the link byte read at a_i+1.
- R3: The ROM read latency is one cycle. Phases alternate value/link, so a list of N nodes raises `done` exactly 2N+2 clock edges after the edge that samples `start` (that edge counts as 1).
- R4: A link byte of 255 ends the walk after the node that carries it. No further node is read.
- R5: A payload counts as a candidate only when it is less than or equal to the bound, and a payload equal to the bound qualifies.
- R6: `result` is the largest candidate in the list.
- R7: With no candidate, `result` is 0 and `found` is 0. A candidate of value 0 gives `result` 0 with `found` 1.
- R8: The bound is captured at start, so changes on `limitX` during a walk do not affect `result`.
- R9: `done` is high for exactly one cycle. `result` and `found` then hold while `limitX` changes, until the next start.
- R10: A `start` pulse while a walk is in progress is ignored, and the walk finishes with the original bound and timing.
- R11: After MAX_NODES (default 256) nodes the walk ends even if the link is not 255. A list that loops on itself then finishes after 2*256+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| limitX | input | 8 | Upper bound for candidate payloads |
| romAddr | output | 8 | ROM read address |
| romData | input | 8 | ROM read data, one cycle after its address |
| done | output | 1 | One-cycle pulse at the end of a walk |
| result | output | 8 | Largest qualifying payload |
| found | output | 1 | At least one payload qualified |

## Verification
Two events can land in the same link-phase cycle: termination by end marker and termination by the step cap. A second `start` can also land in the same cycle as an ongoing walk. The bench provokes the first with a one-node self-loop, whose 256th link is not the marker, and judges the walk by its exact `done` latency. It provokes the second by pulsing `start` with a different bound in the middle of a walk. It then requires the original result, the original latency and the original address sequence.

// File: rtl/llscan_pkg.sv
package llscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRIME,
    ST_VAL,
    ST_LNK
  } scanState_t;

  typedef struct packed {
    logic init;       // clear result, latch bound, address 0
    logic step;       // advance address by one
    logic takeValue;  // ROM word is a payload
    logic takeLink;   // ROM word is a link to follow
    logic linkSel;    // steer ROM word onto address
  } scanCtl_t;
endpackage

// File: rtl/llscan_ctrl.sv
module llscan_ctrl
  import llscan_pkg::*;
#(
  parameter int MAX_NODES = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     isEnd,
  output scanCtl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(MAX_NODES + 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_NODES);

  scanState_t state;
  logic [CNT_W-1:0] nodeCnt;
  logic finish;

  assign finish = isEnd || (nodeCnt == CNT_CAP);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE:  ctl.init = start;
      ST_PRIME: ctl.step = 1'b1;
      ST_VAL:   ctl.takeValue = 1'b1;
      ST_LNK: begin
        ctl.linkSel  = 1'b1;
        ctl.takeLink = !finish;
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nodeCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_PRIME;
          nodeCnt <= '0;
        end
        ST_PRIME: state <= ST_VAL;
        ST_VAL: begin
          state   <= ST_LNK;
          nodeCnt <= nodeCnt + 1'b1;
        end
        ST_LNK: begin
          if (finish) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_VAL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_VALUE_THEN_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VAL) |=> (state == ST_LNK)); // R3
  AST_NODE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    nodeCnt <= CNT_CAP); // R11
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_LNK) |=> (state != ST_PRIME)); // R10
endmodule

// File: rtl/llscan_dp.sv
module llscan_dp
  import llscan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtl_t          ctl,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] result,
  output logic              found,
  output logic              isEnd
);
  localparam logic [DATA_W-1:0] END_MARK = '1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] xQ;
  logic [DATA_W-1:0] maxQ;
  logic              foundQ;
  logic              qualifies;
  logic              better;

  assign isEnd     = (romData == END_MARK);
  assign romAddr   = ctl.linkSel ? ADDR_W'(romData) : addrQ;
  assign qualifies = (romData <= xQ);
  assign better    = !foundQ || (romData > maxQ);
  assign result    = maxQ;
  assign found     = foundQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (ctl.init) begin
      addrQ <= '0;
    end else if (ctl.step) begin
      addrQ <= addrQ + 1'b1;
    end else if (ctl.takeLink) begin
      addrQ <= ADDR_W'(romData) + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xQ     <= '0;
      maxQ   <= '0;
      foundQ <= 1'b0;
    end else if (ctl.init) begin
      xQ     <= xIn;
      maxQ   <= '0;
      foundQ <= 1'b0;
    end else if (ctl.takeValue && qualifies && better) begin
      maxQ   <= romData;
      foundQ <= 1'b1;
    end
  end

  AST_RESULT_WITHIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    foundQ |-> (maxQ <= xQ)); // R5
  AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !foundQ |-> (maxQ == '0)); // R7
  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.init && foundQ) |=> (maxQ >= $past(maxQ))); // R6
endmodule

// File: rtl/llscan.sv
module llscan
  import llscan_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int MAX_NODES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] limitX,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [DATA_W-1:0] romData,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              found
);
  scanCtl_t ctl;
  logic     busy;
  logic     isEnd;

  llscan_ctrl #(.MAX_NODES(MAX_NODES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isEnd(isEnd),
    .ctl(ctl), .busy(busy), .done(done)
  );

  llscan_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xIn(limitX), .romData(romData),
    .romAddr(romAddr), .result(result), .found(found), .isEnd(isEnd)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(result) && $stable(found))); // R9
endmodule

// File: tb/llscan_bench.sv
module llscan_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] limitX = 8'd0;
  logic [7:0] romAddr;
  logic [7:0] romData = 8'd0;
  logic       done;
  logic [7:0] result;
  logic       found;

  int checks = 0;
  int errors = 0;

  logic [7:0] rom [0:255];
  int         slots [0:126];
  int         logA [0:1023];

  always #4 clk = ~clk;

  always @(posedge clk) romData <= rom[romAddr];

  llscan u_llscan (
    .clk(clk), .rstN(rstN), .start(start), .limitX(limitX),
    .romAddr(romAddr), .romData(romData), .done(done),
    .result(result), .found(found)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void refScan(input int x, output int mx, output bit fnd, output int nodes);
    int a;
    int v;
    int p;
    a = 0; mx = 0; fnd = 0; nodes = 0;
    while (1) begin
      v = rom[a];
      nodes++;
      if (v <= x && (!fnd || v > mx)) begin
        mx = v;
        fnd = 1;
      end
      p = rom[(a + 1) % 256];
      if (p == 255 || nodes == 256) break;
      a = p;
    end
  endfunction

  task automatic clearRom();
    for (int i = 0; i < 256; i++) rom[i] = 8'hA5;
  endtask

  // Scatter n nodes over random two-byte slots; node 0 at address 0.
  task automatic makeList(input int n, input int vals [0:127], input bit randVals);
    int t;
    int k;
    int a;
    clearRom();
    for (int j = 0; j < 127; j++) slots[j] = j;
    for (int j = 126; j > 1; j--) begin
      k = 1 + $urandom_range(j - 1);
      t = slots[j]; slots[j] = slots[k]; slots[k] = t;
    end
    for (int i = 0; i < n; i++) begin
      a = 2 * slots[i];
      rom[a] = randVals ? 8'($urandom_range(255)) : 8'(vals[i]);
      rom[a + 1] = (i == n - 1) ? 8'd255 : 8'(2 * slots[i + 1]);
    end
  endtask

  task automatic runScan(input int x, input int restartAt, input int xAlt,
                         input bit chkAddr, input string tag);
    int expMax;
    bit expFnd;
    int nodes;
    int cnt;
    int a;
    bit addrOk;
    int holdR;
    bit holdF;
    refScan(x, expMax, expFnd, nodes);
    limitX = 8'(x);
    start = 1'b1;
    cnt = 0;
    while (cnt < 1000) begin
      logA[cnt] = romAddr;
      @(posedge clk);
      #1;
      if (cnt == 0) start = 1'b0;
      cnt++;
      if (cnt == restartAt) begin
        limitX = 8'(xAlt);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
    // R3 / R11 / R10: exact latency
    chk(cnt == 2 * nodes + 2, {tag, " R3 latency"}, cnt, 2 * nodes + 2);
    // R5 R6 R7 R8: result against reference walk with the original bound
    chk(result == 8'(expMax), {tag, " R6 result"}, result, expMax);
    chk(found == expFnd, {tag, " R7 found"}, found, expFnd);
    if (chkAddr) begin
      // R2 R4: address sequence, no read past the end marker
      addrOk = 1; a = 0;
      for (int i = 0; i < nodes; i++) begin
        if (logA[1 + 2 * i] != a || logA[2 + 2 * i] != ((a + 1) % 256)) addrOk = 0;
        a = rom[(a + 1) % 256];
      end
      chk(addrOk, {tag, " R2 address walk"}, addrOk, 1);
    end
    holdR = result;
    holdF = found;
    @(posedge clk);
    #1;
    chk(done == 1'b0, {tag, " R9 done pulse width"}, done, 0);
    limitX = 8'($urandom_range(255));
    repeat (3) @(posedge clk);
    #1;
    chk(result == 8'(holdR) && found == holdF, {tag, " R9 result hold"}, result, holdR);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vals [0:127];
    int n;
    void'($urandom(32'd20240611));
    clearRom();
    for (int i = 0; i < 128; i++) vals[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(done == 0 && found == 0 && result == 0 && romAddr == 0, "R1 reset state",
        {done, found, result, romAddr}, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R4 single node, end marker on first link
    vals[0] = 5;
    makeList(1, vals, 0);
    runScan(10, -1, 0, 1, "single R4");

    // R5 payload equal to bound qualifies
    vals[0] = 7; vals[1] = 9; vals[2] = 3;
    makeList(3, vals, 0);
    runScan(9, -1, 0, 1, "equal R5");

    // R7 no candidate
    vals[0] = 20; vals[1] = 30;
    makeList(2, vals, 0);
    runScan(10, -1, 0, 1, "none R7");

    // R7 zero payload is a real candidate
    vals[0] = 50; vals[1] = 0; vals[2] = 60;
    makeList(3, vals, 0);
    runScan(0, -1, 0, 1, "zero R7");

    // R6 full bound
    vals[0] = 12; vals[1] = 255; vals[2] = 254;
    makeList(3, vals, 0);
    runScan(255, -1, 0, 1, "fullX R6");

    // R8 + R10: restart request with another bound mid-walk
    vals[0] = 40; vals[1] = 90; vals[2] = 70; vals[3] = 10; vals[4] = 100;
    makeList(5, vals, 0);
    runScan(80, 5, 200, 1, "restart R8 R10");
    runScan(80, 4, 5, 1, "restart2 R8 R10");

    // R11 self-loop: node at 0 links back to 0
    clearRom();
    rom[0] = 8'd4; rom[1] = 8'd0;
    runScan(200, -1, 0, 0, "loop R11");

    // random lists
    for (int r = 0; r < 30; r++) begin
      n = 1 + $urandom_range(39);
      makeList(n, vals, 1);
      runScan($urandom_range(255), -1, 0, 1, "random R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule